// File: doc/BRIEF.md
# I2C Slave Address Recognizer

This block listens to an already synchronised SDA/SCL pair, finds START and STOP conditions, and gathers the first byte that follows each START. The upper seven bits of that byte are compared against a programmable own address. Optionally, the all-zero general call byte is accepted as well. When the byte is accepted, the block raises a selection flag, reports the direction bit and asks the pad logic to pull SDA low for the acknowledge clock.

Software programs one 8-bit register. The seven address bits sit in the top of this register, and the general call enable sits in its lowest bit. The bus is looked at only on cycles where the sampling tick is high. The tick rate must be at least 500 kHz so that a START issued by another master is not missed.

The recognizer is disarmed while the local master is sending its own address. If that master reports lost arbitration before the byte ends, the recognizer is re-armed for the same byte. This lets the winning master's address still select this device.

Top module: `i2c_slave_addr_match`

## Requirements
- R1: The address register resets to 00h. A write through `reg_we` shows on `reg_rdata` on the next clock. Bits [7:1] hold the own address and bit 0 enables the general call.
- R2: A START is SDA going 1 to 0 while SCL stays 1 between two ticks, and it begins a new address byte. A STOP is SDA going 0 to 1 while SCL stays 1, and it clears `match_own`, `match_gc`, `slave_sel`, `rw_bit` and `ack_drive`.
- R3: Bits are shifted in MSB first on each SCL 0 to 1 transition seen at a tick. After the 8th bit, `match_own` and `slave_sel` rise on the next clock if byte bits [7:1] equal register bits [7:1].
- R4: A received byte of 00h sets `match_gc` (and `slave_sel`) only when register bit 0 is 1.
- R5: On a match, `rw_bit` holds the 8th received bit (1 = read, 0 = write) until the next START or STOP.
- R6: After a match, `ack_drive` is high from the SCL 1 to 0 transition that ends the 8th bit until the SCL 1 to 0 transition that ends the 9th bit. It is never high without a match.
- R7: If `master_active` is high at START, no match is reported for that byte, unless `arb_lost` is pulsed before the 8th bit is taken.
- R8: A START arriving partway through the address byte drops the bits already gathered and restarts the count.
- R9: Cycles with `tick` low change neither the bus history nor any output flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Bus sampling enable |
| sda_in | input | 1 | Synchronised SDA level |
| scl_in | input | 1 | Synchronised SCL level |
| master_active | input | 1 | Local master is driving the current address |
| arb_lost | input | 1 | Local master lost arbitration (pulse) |
| reg_we | input | 1 | Address register write strobe |
| reg_wdata | input | 8 | Address register write data |
| reg_rdata | output | 8 | Address register contents |
| match_own | output | 1 | Own address recognised |
| match_gc | output | 1 | General call recognised |
| slave_sel | output | 1 | Either match is active |
| rw_bit | output | 1 | Direction bit of the matched byte |
| ack_drive | output | 1 | Request to pull SDA low for acknowledge |

## Verification
The internal state that matters here is the bit count and the armed flag, and neither can be seen directly at the ports. A count that is off by one shows up as a wrong `rw_bit` or as `ack_drive` appearing one SCL clock early or late. A stale armed flag shows up as a false selection on a suppressed byte. The reference model is compared with the design on every clock, so any such error is reported on the first clock where the flags or the acknowledge request differ, at the latest one SCL period after the 8th bit.

// File: rtl/sar_pkg.sv
package sar_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_PRE_ACK,
      ST_ACK,
      ST_HOLD
   } sar_state_e;
endpackage

// File: rtl/sar_bus_sampler.sv
module sar_bus_sampler (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic sda_in,
   input  logic scl_in,
   output logic ev_start,
   output logic ev_stop,
   output logic ev_rise,
   output logic ev_fall
);
   logic sda_l, scl_l;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sda_l <= 1'b1;
         scl_l <= 1'b1;
      end else if (tick) begin
         sda_l <= sda_in;
         scl_l <= scl_in;
      end
   end

   // events compare the current pins against the last ticked sample
   assign ev_start = tick & scl_l & scl_in & sda_l & ~sda_in;
   assign ev_stop  = tick & scl_l & scl_in & ~sda_l & sda_in;
   assign ev_rise  = tick & ~scl_l & scl_in;
   assign ev_fall  = tick & scl_l & ~scl_in;
endmodule

// File: rtl/sar_addr_shift.sv
module sar_addr_shift #(
   parameter int ADDR_BITS = 7
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clr,
   input  logic                 shift_en,
   input  logic                 bit_in,
   output logic [ADDR_BITS:0]   next_byte,
   output logic [$clog2(ADDR_BITS+2)-1:0] count
);
   localparam int CNT_W = $clog2(ADDR_BITS + 2);

   logic [ADDR_BITS-1:0] sh_q;
   logic [CNT_W-1:0]     cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q  <= '0;
         cnt_q <= '0;
      end else if (clr) begin
         sh_q  <= '0;
         cnt_q <= '0;
      end else if (shift_en) begin
         sh_q  <= next_byte[ADDR_BITS-1:0];
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign next_byte = {sh_q, bit_in};
   assign count     = cnt_q;
endmodule

// File: rtl/sar_compare.sv
module sar_compare #(
   parameter int ADDR_BITS  = 7,
   parameter bit GC_SUPPORT = 1'b1
) (
   input  logic [ADDR_BITS:0] rx_byte,
   input  logic [ADDR_BITS:0] cfg,
   output logic               hit_own,
   output logic               hit_gc
);
   assign hit_own = (rx_byte[ADDR_BITS:1] == cfg[ADDR_BITS:1]);

   generate
      if (GC_SUPPORT) begin : g_gc
         assign hit_gc = cfg[0] & (rx_byte == '0);
      end else begin : g_no_gc
         assign hit_gc = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/i2c_slave_addr_match.sv
module i2c_slave_addr_match #(
   parameter int ADDR_BITS  = 7,
   parameter bit GC_SUPPORT = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick,
   input  logic               sda_in,
   input  logic               scl_in,
   input  logic               master_active,
   input  logic               arb_lost,
   input  logic               reg_we,
   input  logic [ADDR_BITS:0] reg_wdata,
   output logic [ADDR_BITS:0] reg_rdata,
   output logic               match_own,
   output logic               match_gc,
   output logic               slave_sel,
   output logic               rw_bit,
   output logic               ack_drive
);
   import sar_pkg::*;

   localparam int BYTE_W = ADDR_BITS + 1;
   localparam int CNT_W  = $clog2(ADDR_BITS + 2);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

   generate
      if (ADDR_BITS < 1 || ADDR_BITS > 10) begin : g_bad_width
         $error("ADDR_BITS out of supported range");
      end
   endgenerate

   logic [BYTE_W-1:0] addr_q;
   logic              ev_start, ev_stop, ev_rise, ev_fall;
   logic [BYTE_W-1:0] next_byte;
   logic [CNT_W-1:0]  count;
   logic              hit_own, hit_gc;
   logic              armed_q, armed_now;
   logic              own_q, gc_q, rw_q;
   logic              shift_en, last_bit;
   sar_state_e        state_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      addr_q <= '0;
      else if (reg_we) addr_q <= reg_wdata;
   end

   sar_bus_sampler u_sampler (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .sda_in   (sda_in),
      .scl_in   (scl_in),
      .ev_start (ev_start),
      .ev_stop  (ev_stop),
      .ev_rise  (ev_rise),
      .ev_fall  (ev_fall)
   );

   assign shift_en = (state_q == ST_ADDR) & ev_rise;
   assign last_bit = shift_en & (count == LAST_BIT);

   sar_addr_shift #(.ADDR_BITS(ADDR_BITS)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (ev_start),
      .shift_en  (shift_en),
      .bit_in    (sda_in),
      .next_byte (next_byte),
      .count     (count)
   );

   sar_compare #(.ADDR_BITS(ADDR_BITS), .GC_SUPPORT(GC_SUPPORT)) u_cmp (
      .rx_byte (next_byte),
      .cfg     (addr_q),
      .hit_own (hit_own),
      .hit_gc  (hit_gc)
   );

   assign armed_now = armed_q | arb_lost;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         armed_q <= 1'b0;
         own_q   <= 1'b0;
         gc_q    <= 1'b0;
         rw_q    <= 1'b0;
      end else if (ev_start) begin
         state_q <= ST_ADDR;
         armed_q <= ~master_active;
         own_q   <= 1'b0;
         gc_q    <= 1'b0;
         rw_q    <= 1'b0;
      end else if (ev_stop) begin
         state_q <= ST_IDLE;
         own_q   <= 1'b0;
         gc_q    <= 1'b0;
         rw_q    <= 1'b0;
      end else begin
         unique case (state_q)
            ST_ADDR: begin
               armed_q <= armed_now;
               if (last_bit) begin
                  if (armed_now && (hit_own || hit_gc)) begin
                     own_q   <= hit_own;
                     gc_q    <= hit_gc;
                     rw_q    <= next_byte[0];
                     state_q <= ST_PRE_ACK;
                  end else begin
                     state_q <= ST_HOLD;
                  end
               end
            end
            ST_PRE_ACK: if (ev_fall) state_q <= ST_ACK;
            ST_ACK:     if (ev_fall) state_q <= ST_HOLD;
            default: ;
         endcase
      end
   end

   assign reg_rdata = addr_q;
   assign match_own = own_q;
   assign match_gc  = gc_q;
   assign slave_sel = own_q | gc_q;
   assign rw_bit    = rw_q;
   assign ack_drive = (state_q == ST_ACK);
endmodule

// File: rtl/sar_checker.sv
module sar_checker #(
   parameter int ADDR_BITS = 7
) (
   input logic               clk,
   input logic               rst_n,
   input logic               tick,
   input logic               scl_in,
   input logic               reg_we,
   input logic [ADDR_BITS:0] reg_wdata,
   input logic [ADDR_BITS:0] reg_rdata,
   input logic               match_own,
   input logic               match_gc,
   input logic               slave_sel,
   input logic               rw_bit,
   input logic               ack_drive
);
   assert_reg_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |=> (reg_rdata == $past(reg_wdata)));

   assert_sel_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(slave_sel) |-> ($past(tick) && $past(scl_in)));

   assert_gc_needs_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(match_gc) |-> $past(reg_rdata[0]));

   assert_ack_only_selected_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ack_drive |-> slave_sel);

   assert_ack_starts_scl_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ack_drive) |-> !$past(scl_in));

   assert_quiet_without_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !reg_we) |=> $stable({match_own, match_gc, rw_bit, ack_drive}));
endmodule

bind i2c_slave_addr_match sar_checker #(.ADDR_BITS(ADDR_BITS)) u_sar_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .tick      (tick),
   .scl_in    (scl_in),
   .reg_we    (reg_we),
   .reg_wdata (reg_wdata),
   .reg_rdata (reg_rdata),
   .match_own (match_own),
   .match_gc  (match_gc),
   .slave_sel (slave_sel),
   .rw_bit    (rw_bit),
   .ack_drive (ack_drive)
);

// File: tb/test_i2c_slave_addr_match.sv
module test_i2c_slave_addr_match;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick = 1'b0;
   logic sda_in = 1'b1, scl_in = 1'b1;
   logic master_active = 1'b0, arb_lost = 1'b0;
   logic reg_we = 1'b0;
   logic [7:0] reg_wdata = 8'h00;
   logic [7:0] reg_rdata;
   logic match_own, match_gc, slave_sel, rw_bit, ack_drive;

   int checks = 0, errors = 0, cyc = 0;
   bit tick_en = 1'b1, done = 1'b0;

   always #2.5 clk = ~clk;

   i2c_slave_addr_match i_i2c_slave_addr_match (
      .clk(clk), .rst_n(rst_n), .tick(tick), .sda_in(sda_in), .scl_in(scl_in),
      .master_active(master_active), .arb_lost(arb_lost),
      .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .match_own(match_own), .match_gc(match_gc), .slave_sel(slave_sel),
      .rw_bit(rw_bit), .ack_drive(ack_drive)
   );

   // reference model: 0 idle, 1 address, 2 wait ack, 3 ack, 4 hold
   int m_state = 0, m_cnt = 0;
   bit m_sda_l = 1, m_scl_l = 1, m_armed = 0, m_own = 0, m_gc = 0, m_rw = 0;
   bit [7:0] m_byte = 0, m_reg = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_state = 0; m_cnt = 0; m_sda_l = 1; m_scl_l = 1; m_armed = 0;
         m_own = 0; m_gc = 0; m_rw = 0; m_byte = 0; m_reg = 0;
      end else begin
         bit st, sp, rise, fall;
         st   = tick && m_scl_l && scl_in && m_sda_l && !sda_in;
         sp   = tick && m_scl_l && scl_in && !m_sda_l && sda_in;
         rise = tick && !m_scl_l && scl_in;
         fall = tick && m_scl_l && !scl_in;
         if (st) begin
            m_state = 1; m_cnt = 0; m_byte = 0; m_own = 0; m_gc = 0; m_rw = 0;
            m_armed = !master_active;
         end else if (sp) begin
            m_state = 0; m_own = 0; m_gc = 0; m_rw = 0;
         end else if (m_state == 1) begin
            if (arb_lost) m_armed = 1;
            if (rise) begin
               m_byte = {m_byte[6:0], sda_in};
               m_cnt++;
               if (m_cnt == 8) begin
                  bit o, g;
                  o = (m_byte[7:1] == m_reg[7:1]);
                  g = m_reg[0] && (m_byte == 8'h00);
                  if (m_armed && (o || g)) begin
                     m_own = o; m_gc = g; m_rw = m_byte[0]; m_state = 2;
                  end else m_state = 4;
               end
            end
         end else if (m_state == 2 && fall) m_state = 3;
         else if (m_state == 3 && fall) m_state = 4;
         if (tick) begin m_sda_l = sda_in; m_scl_l = scl_in; end
         if (reg_we) m_reg = reg_wdata;
      end
   end

   task automatic chk(string req, int act, int exp, string what);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d at cycle %0d", req, what, act, exp, cyc);
      end
   endtask

   // per-clock comparison against the model
   always @(negedge clk) begin
      cyc++;
      if (rst_n && !done) begin
         chk("R1", reg_rdata, m_reg, "reg_rdata");
         chk("R3", match_own, m_own, "match_own");
         chk("R4", match_gc, m_gc, "match_gc");
         chk("R3", slave_sel, m_own | m_gc, "slave_sel");
         chk("R5", rw_bit, m_rw, "rw_bit");
         chk("R6", ack_drive, m_state == 3, "ack_drive");
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #(5.0 * 150000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      @(negedge clk);
      forever begin
         tick = tick_en ? ~tick : 1'b0;
         @(negedge clk);
      end
   end

   task automatic step(bit s, bit c);
      sda_in = s; scl_in = c;
      repeat (4) @(negedge clk);
   endtask
   task automatic send_start(); step(1, 1); step(0, 1); step(0, 0); endtask
   task automatic send_stop();  step(0, 0); step(0, 1); step(1, 1); endtask
   task automatic send_bit(bit b); step(b, 0); step(b, 1); step(b, 0); endtask
   task automatic send_byte(bit [7:0] v);
      for (int i = 7; i >= 0; i--) send_bit(v[i]);
   endtask
   task automatic write_reg(bit [7:0] v);
      reg_wdata = v; reg_we = 1'b1; @(negedge clk); reg_we = 1'b0; @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R1", reg_rdata, 0, "reset register");
      chk("R2", slave_sel, 0, "reset select");
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      write_reg(8'hB4);                       // address 5Ah, general call off
      chk("R1", reg_rdata, 8'hB4, "readback");

      // own address, read
      send_start(); send_byte(8'hB5);
      chk("R3", match_own, 1, "own match");
      chk("R5", rw_bit, 1, "read direction");
      step(1, 0);
      chk("R6", ack_drive, 1, "ack during 9th clock");
      step(1, 1); step(1, 0);
      chk("R6", ack_drive, 0, "ack released");
      send_stop();
      chk("R2", slave_sel, 0, "stop clears");

      // wrong address
      send_start(); send_byte(8'hB6); send_bit(1);
      chk("R3", slave_sel, 0, "mismatch");
      send_stop();

      // general call disabled then enabled
      send_start(); send_byte(8'h00); send_bit(1);
      chk("R4", match_gc, 0, "gc disabled");
      send_stop();
      write_reg(8'hB5);
      send_start(); send_byte(8'h00);
      chk("R4", match_gc, 1, "gc enabled");
      chk("R5", rw_bit, 0, "gc write direction");
      send_bit(1); send_stop();

      // local master active: suppressed, then arbitration lost
      master_active = 1'b1;
      send_start(); master_active = 1'b0; send_byte(8'hB4); send_bit(1);
      chk("R7", slave_sel, 0, "suppressed while mastering");
      send_stop();
      master_active = 1'b1;
      send_start(); master_active = 1'b0;
      send_bit(1); send_bit(0); send_bit(1);
      arb_lost = 1'b1; @(negedge clk); arb_lost = 1'b0;
      send_bit(1); send_bit(0); send_bit(1); send_bit(0); send_bit(0);
      chk("R7", match_own, 1, "re-armed by lost arbitration");
      send_bit(1); send_stop();

      // repeated START part way through the address
      send_start(); send_bit(0); send_bit(1); send_bit(1); send_bit(0);
      step(1, 0); step(1, 1); step(0, 1); step(0, 0);
      send_byte(8'hB4);
      chk("R8", match_own, 1, "restart after repeated START");
      send_bit(1); send_stop();

      // bus activity without tick is ignored
      tick_en = 1'b0;
      step(1, 1); step(0, 1); step(1, 1);
      tick_en = 1'b1;
      repeat (4) @(negedge clk);
      send_byte(8'hB4);
      chk("R9", slave_sel, 0, "no START seen without tick");
      send_stop();

      repeat (4) @(negedge clk);
      finish_run();
   end
endmodule